// File: doc/BRIEF.md
# Overlap Cell Push Arbiter

This block collects updated road cells from several parallel update engines and funnels them onto one output stream toward the host link. Every engine offers at most one cell word per cycle together with a flag saying whether the cell sits in a region shared with software. Only flagged cells are kept. All other cells are thrown away at the input. Each kept cell goes into a small FIFO that belongs to its engine, so that short bursts of shared-region traffic do not need to be met by the host at once.

A round-robin selector picks one non-empty FIFO per transfer and routes its head word, together with the engine index, through a multiplexer onto a valid/ready output. The engines never see backpressure. While forwarding goes on, they keep producing. When a FIFO is already full as a flagged cell arrives, that cell is lost, and a sticky per-engine overflow bit records the loss until reset.

Top module: `ovl_push_arbiter`

## Requirements
- R1: A cell enters its engine's FIFO only when both its valid bit and its overlap bit are 1. Any other cell leaves every FIFO and the output unchanged.
- R2: Each of the four engines has its own FIFO of 16 entries. Words from one engine leave in the order in which they were admitted.
- R3: A cell that arrives valid and flagged while its FIFO holds 16 entries is dropped, even if the same cycle pops that FIFO. The engine's bit in `fifo_ovf` (bit i for engine i) then goes to 1 on the next edge and stays 1 until reset.
- R4: `fifo_empty[i]` is 1 exactly when FIFO i holds 0 entries. `fifo_full[i]` is 1 exactly when it holds 16 entries. Both are updated on the clock edge that changes the occupancy.
- R5: `out_valid` is 1 exactly when at least one FIFO is non-empty. `out_data` is then the oldest word of the granted FIFO, and `out_eng` is that FIFO's 2-bit index.
- R6: The grant goes to the first non-empty FIFO found when searching upward from the round-robin pointer and wrapping from index 3 to index 0. The pointer is 0 after reset. After an accepted transfer (`out_valid` and `out_ready` both 1), the pointer becomes the granted index plus 1, modulo 4.
- R7: While `out_valid` is 1 and `out_ready` is 0, the next cycle keeps `out_valid` at 1 and holds `out_data` and `out_eng` unchanged, even if other FIFOs become non-empty.
- R8: The engine inputs have no ready signal. A push and a pop of the same non-full FIFO in one cycle both take effect.
- R9: After reset, every FIFO is empty and none is full, all overflow bits are 0, and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| eng_valid | input | 4 | Per-engine cell valid |
| eng_overlap | input | 4 | Per-engine shared-region flag |
| eng_cell | input | 128 | Cell words, engine i at bits [32*i+31:32*i] |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Host side accepts the word |
| out_data | output | 32 | Forwarded cell word |
| out_eng | output | 2 | Index of the engine the word came from |
| fifo_empty | output | 4 | Per-FIFO empty status |
| fifo_full | output | 4 | Per-FIFO full status |
| fifo_ovf | output | 4 | Sticky per-engine overflow flags |

## Verification
The assertions check, on every cycle, the rules that can be seen locally:
- A stalled word stays stable.
- The granted FIFO is never empty.
- Empty and full are never set together.
- The overflow bits are sticky and are set by a flagged arrival at a full FIFO.
- A FIFO whose engine pushes nothing and that is not popped keeps its status.

Only the bench's scenarios can show that words come out in the exact round-robin and per-engine order with the right contents. The same goes for the drop of a cell that arrives at a full FIFO during a pop. Both need a full model of the queues and the pointer.

// File: rtl/ovl_push_pkg.sv
// Package: shared defaults and index arithmetic for the overlap push arbiter.
// Assumes: engine indices are small non-negative integers.
package ovl_push_pkg;
    localparam int DEF_NUM_ENG = 4;
    localparam int DEF_CELL_W  = 32;
    localparam int DEF_DEPTH   = 16;

    // Next index in round-robin order, wrapping at n.
    function automatic int rr_next(input int idx, input int n);
        return (idx + 1) % n;
    endfunction
endpackage

// File: rtl/ovl_cell_fifo.sv
// Module: per-engine cell FIFO with first-word fall-through read and a
// sticky overflow flag.
// Assumes: rd_en is asserted only while the FIFO is non-empty. A write that
// finds the FIFO full is discarded even when a read occurs in the same cycle.
module ovl_cell_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_req,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         full,
    output logic         overflow
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          ovf_q;
    logic          do_wr, do_rd;

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_wr   = wr_req && !full;
    assign do_rd   = rd_en && !empty;
    assign rd_data = mem[rp_q];
    assign overflow = ovf_q;

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wp_q] <= wr_data;
    end

    // Pointers, occupancy and sticky overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            if (do_wr) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
            if (do_rd) rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
            if (wr_req && full) ovf_q <= 1'b1;
        end
    end
endmodule

// File: rtl/ovl_rr_arb.sv
// Module: round-robin grant over request lines. It searches upward from a
// pointer, skipping idle requesters in the same cycle, and locks the grant
// while a granted transfer waits for acceptance.
// Assumes: a granted request stays high until it is accepted.
module ovl_rr_arb #(
    parameter int N = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         req,
    input  logic                 accept,
    output logic                 grant_valid,
    output logic [$clog2(N)-1:0] grant_idx
);
    import ovl_push_pkg::*;
    localparam int IW = $clog2(N);

    logic [IW-1:0] ptr_q, lock_idx_q, pick;
    logic          lock_q, found;

    // Find the first requester at or after the pointer.
    always_comb begin
        pick  = '0;
        found = 1'b0;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = (int'(ptr_q) + k) % N;
            if (!found && req[idx]) begin
                pick  = IW'(idx);
                found = 1'b1;
            end
        end
    end

    // A locked grant overrides the search.
    always_comb begin
        if (lock_q) begin
            grant_valid = 1'b1;
            grant_idx   = lock_idx_q;
        end else begin
            grant_valid = found;
            grant_idx   = pick;
        end
    end

    // Pointer advance on accept; lock while stalled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q      <= '0;
            lock_q     <= 1'b0;
            lock_idx_q <= '0;
        end else begin
            if (grant_valid && accept) ptr_q <= IW'(rr_next(int'(grant_idx), N));
            lock_q     <= grant_valid && !accept;
            lock_idx_q <= grant_idx;
        end
    end
endmodule

// File: rtl/ovl_push_arbiter.sv
// Module: top of the overlap push arbiter. It admits flagged cells into
// per-engine FIFOs and drains them round-robin onto one valid/ready stream.
// Assumes: engines cannot be stalled, so a cell that arrives at a full FIFO
// is lost and flagged.
module ovl_push_arbiter #(
    parameter int NUM_ENG = ovl_push_pkg::DEF_NUM_ENG,
    parameter int CELL_W  = ovl_push_pkg::DEF_CELL_W,
    parameter int DEPTH   = ovl_push_pkg::DEF_DEPTH,
    localparam int IW     = $clog2(NUM_ENG)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_ENG-1:0]        eng_valid,
    input  logic [NUM_ENG-1:0]        eng_overlap,
    input  logic [NUM_ENG*CELL_W-1:0] eng_cell,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic [CELL_W-1:0]         out_data,
    output logic [IW-1:0]             out_eng,
    output logic [NUM_ENG-1:0]        fifo_empty,
    output logic [NUM_ENG-1:0]        fifo_full,
    output logic [NUM_ENG-1:0]        fifo_ovf
);
    logic [CELL_W-1:0]  head [NUM_ENG];
    logic [NUM_ENG-1:0] rd_en;
    logic               grant_valid;
    logic [IW-1:0]      grant_idx;
    logic               accept;

    assign accept = grant_valid && out_ready;

    // One FIFO per engine; the admission filter sits at its write port.
    for (genvar i = 0; i < NUM_ENG; i++) begin : g_eng
        assign rd_en[i] = accept && (grant_idx == IW'(i));
        ovl_cell_fifo #(.W(CELL_W), .DEPTH(DEPTH)) u_fifo (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_req   (eng_valid[i] && eng_overlap[i]),
            .wr_data  (eng_cell[i*CELL_W +: CELL_W]),
            .rd_en    (rd_en[i]),
            .rd_data  (head[i]),
            .empty    (fifo_empty[i]),
            .full     (fifo_full[i]),
            .overflow (fifo_ovf[i])
        );
    end

    ovl_rr_arb #(.N(NUM_ENG)) u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (~fifo_empty),
        .accept      (out_ready),
        .grant_valid (grant_valid),
        .grant_idx   (grant_idx)
    );

    // Output multiplexer driven by the grant.
    assign out_valid = grant_valid;
    assign out_data  = head[grant_idx];
    assign out_eng   = grant_idx;
endmodule

// File: rtl/ovl_push_arbiter_chk.sv
// Module: assertion checker for the overlap push arbiter, bound to the top.
// Assumes: it observes only the top-level ports.
module ovl_push_arbiter_chk #(
    parameter int NUM_ENG = 4,
    parameter int CELL_W  = 32,
    localparam int IW     = $clog2(NUM_ENG)
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NUM_ENG-1:0]        eng_valid,
    input logic [NUM_ENG-1:0]        eng_overlap,
    input logic                      out_valid,
    input logic                      out_ready,
    input logic [CELL_W-1:0]         out_data,
    input logic [IW-1:0]             out_eng,
    input logic [NUM_ENG-1:0]        fifo_empty,
    input logic [NUM_ENG-1:0]        fifo_full,
    input logic [NUM_ENG-1:0]        fifo_ovf
);
    p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_eng));

    p_grant_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !fifo_empty[out_eng]);

    p_idle_when_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (&fifo_empty) |-> !out_valid);

    for (genvar i = 0; i < NUM_ENG; i++) begin : g_chk
        p_status_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !(fifo_empty[i] && fifo_full[i]));

        p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
            fifo_ovf[i] |=> fifo_ovf[i]);

        p_ovf_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
            eng_valid[i] && eng_overlap[i] && fifo_full[i] |=> fifo_ovf[i]);

        p_filter_r1: assert property (@(posedge clk) disable iff (!rst_n)
            !(eng_valid[i] && eng_overlap[i]) && !(out_valid && out_ready && int'(out_eng) == i)
            |=> $stable(fifo_empty[i]) && $stable(fifo_full[i]));
    end
endmodule

bind ovl_push_arbiter ovl_push_arbiter_chk #(.NUM_ENG(NUM_ENG), .CELL_W(CELL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .eng_valid   (eng_valid),
    .eng_overlap (eng_overlap),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_data    (out_data),
    .out_eng     (out_eng),
    .fifo_empty  (fifo_empty),
    .fifo_full   (fifo_full),
    .fifo_ovf    (fifo_ovf)
);

// File: tb/ovl_push_arbiter_tb.sv
module ovl_push_arbiter_tb;
    localparam int N = 4;
    localparam int W = 32;
    localparam int D = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   eng_valid = '0;
    logic [N-1:0]   eng_overlap = '0;
    logic [N*W-1:0] eng_cell = '0;
    logic           out_valid;
    logic           out_ready = 1'b0;
    logic [W-1:0]   out_data;
    logic [1:0]     out_eng;
    logic [N-1:0]   fifo_empty, fifo_full, fifo_ovf;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // Queue model.
    logic [W-1:0] mq [N][D];
    int mhead [N];
    int mcnt [N];
    bit movf [N];
    int mptr = 0;
    bit mlock = 0;
    int mlock_idx = 0;
    int seq = 0;

    always #2 clk = ~clk;

    ovl_push_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .eng_valid(eng_valid), .eng_overlap(eng_overlap),
        .eng_cell(eng_cell), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_eng(out_eng), .fifo_empty(fifo_empty),
        .fifo_full(fifo_full), .fifo_ovf(fifo_ovf)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, compare with the model, then advance the model.
    task automatic step(input logic [N-1:0] v, input logic [N-1:0] o, input logic rdy);
        int g;
        bit ev;
        bit was_full [N];
        @(negedge clk);
        eng_valid = v;
        eng_overlap = o;
        out_ready = rdy;
        for (int i = 0; i < N; i++) eng_cell[i*W +: W] = {8'(i), 24'(seq + i)};
        seq += N;
        #1;
        ev = 0;
        g = 0;
        if (mlock) begin
            ev = 1; g = mlock_idx;
        end else begin
            for (int k = 0; k < N; k++)
                if (!ev && mcnt[(mptr + k) % N] > 0) begin ev = 1; g = (mptr + k) % N; end
        end
        for (int i = 0; i < N; i++) begin
            check("R4 empty", W'(fifo_empty[i]), W'(mcnt[i] == 0));
            check("R4 full", W'(fifo_full[i]), W'(mcnt[i] == D));
            check("R3 ovf", W'(fifo_ovf[i]), W'(movf[i]));
        end
        check("R5 valid", W'(out_valid), W'(ev));
        if (ev) begin
            check("R6 engine index", W'(out_eng), W'(g));
            check("R2 data order", out_data, mq[g][mhead[g]]);
        end
        for (int i = 0; i < N; i++) was_full[i] = (mcnt[i] == D);
        if (ev && rdy) begin
            mhead[g] = (mhead[g] + 1) % D;
            mcnt[g]--;
            mptr = (g + 1) % N;
        end
        mlock = ev && !rdy;
        mlock_idx = g;
        for (int i = 0; i < N; i++)
            if (v[i] && o[i]) begin
                if (was_full[i]) movf[i] = 1;
                else begin
                    mq[i][(mhead[i] + mcnt[i]) % D] = eng_cell[i*W +: W];
                    mcnt[i]++;
                end
            end
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin mhead[i] = 0; mcnt[i] = 0; movf[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        #1;
        check("R9 valid", W'(out_valid), 0);
        check("R9 empty", W'(fifo_empty), W'(4'hF));
        check("R9 full", W'(fifo_full), 0);
        check("R9 ovf", W'(fifo_ovf), 0);
        // R1: valid cells without the flag, and flagged cells without valid, are ignored
        for (int c = 0; c < 12; c++) step(c[0] ? 4'hF : 4'h0, c[0] ? 4'h0 : 4'hF, 1'b1);
        // R2/R6: single engine stream, then all engines at once
        for (int c = 0; c < 8; c++) step(4'b0100, 4'b0100, c[1]);
        for (int c = 0; c < 6; c++) step(4'hF, 4'hF, 1'b1);
        for (int c = 0; c < 30; c++) step(4'h0, 4'h0, 1'b1);
        // R7: stalls while other FIFOs fill
        for (int c = 0; c < 20; c++) step(4'b1011, 4'hF, (c % 4) == 3);
        for (int c = 0; c < 40; c++) step(4'h0, 4'h0, 1'b1);
        // R3: overflow on engine 2 with no drain
        for (int c = 0; c < 20; c++) step(4'b0100, 4'b0100, 1'b0);
        // R3/R8: full FIFO pushed while popped -> cell dropped
        step(4'b0100, 4'b0100, 1'b1);
        for (int c = 0; c < 20; c++) step(4'h0, 4'h0, 1'b1);
        // R6/R8: sweep of all valid/overlap mask pairs
        for (int m = 0; m < 256; m++) step(m[3:0], m[7:4], (m % 3) != 0);
        for (int c = 0; c < 70; c++) step(4'h0, 4'h0, 1'b1);
        // R8: dense pushes with mixed ready patterns
        for (int m = 0; m < 512; m++) step(4'(m ^ (m >> 3)), 4'(~(m >> 2)), (m % 5) > 1);
        for (int c = 0; c < 70; c++) step(4'h0, 4'h0, 1'b1);
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule